// File: doc/BRIEF.md
# Sequence-Unlocked Indirect Register Backdoor

This block decodes a six-byte legacy I/O port window. The window has a 32-bit data port at offset 0 and a 16-bit address port at offset 4. Most traffic passes straight through to a backing register file. A fixed chain of writes with magic values opens a single indirect access into a 256-byte configuration array.

The chain has three steps. First, 0x338 is written to the address port. Next, a value of the form 0x18xx is written to the data port; its low byte becomes the target offset. Finally, 0x538 (arm a read) or 0x738 (arm a write) is written to the address port. The one access that follows is then served by the array instead of the backing registers. Any read, and any write that breaks the chain, drops the sequencer back to idle.

Writes and read data take effect in the same cycle as the strobe. The sequencer state and the array update on the following clock edge. The read and write strobes are never driven together.

Top module: `port_cfg_backdoor`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in idle, clears the latched offset and zeroes every byte of the configuration array.
- R2: In idle, a write whose masked value is 0x338 at port offset 4 moves to the select step. Any other write leaves the sequencer in idle.
- R3: In the select step, a write to offset 0 whose masked value, with its low 8 bits cleared, equals 0x1800 latches those low 8 bits as the target offset and moves to the window step. Any other write returns to idle.
- R4: In the window step, a write to offset 4 of value 0x538 arms a read and a write of 0x738 arms a write. Any other write returns to idle.
- R5: While write-armed, a write to offset 0 stores its low size bytes, little-endian, into the array starting at the latched offset. It is not forwarded to the backing port. The sequencer then returns to idle; a write-armed write to any other offset is forwarded and also returns to idle.
- R6: Every read is forwarded on the backing read strobe and returns the sequencer to idle. A read of offset 0 while read-armed returns the array bytes at the latched offset, zero-extended by size, instead of the backing data.
- R7: Every write not consumed under R5 is forwarded unchanged on the backing port in the same cycle, including the unlock writes. Every read outside R6's armed case returns the backing read data unchanged.
- R8: A write while read-armed returns the sequencer to idle and is forwarded.
- R9: Multi-byte array accesses wrap modulo 256 past offset 255.
- R10: Magic comparisons use the write data masked to the access size. Size code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Port write strobe |
| bus_rd | input | 1 | Port read strobe |
| bus_addr | input | 3 | Byte offset in the window |
| bus_size | input | 2 | Access size code (R10) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bk_wr | output | 1 | Backing write strobe |
| bk_rd | output | 1 | Backing read strobe |
| bk_addr | output | 3 | Backing offset |
| bk_size | output | 2 | Backing size code |
| bk_wdata | output | 32 | Backing write data |
| bk_rdata | input | 32 | Backing read data |

## Verification
Every unlock step is two things in one cycle. It is a write forwarded to the backing port, and it is a transition of the sequencer. The bench therefore checks the forwarded strobe, address, data and size in the same cycle as each key write. It then judges the transition by the data a later armed read returns.

A read is also two things at once. It delivers data, either from the array or from the backing port. It also resets the sequencer. Random interleaving of reads into half-built chains checks that the returned data and the return to idle agree with a reference model kept in the bench.

// File: rtl/ixwin_pkg.sv
package ixwin_pkg;
    localparam int PORT_AW   = 3;
    localparam int DW        = 32;
    localparam int CFG_DEPTH = 256;
    localparam int OFF_W     = $clog2(CFG_DEPTH);
    localparam int LANES     = DW / 8;

    localparam logic [PORT_AW-1:0] DATA_PORT = 3'd0;
    localparam logic [PORT_AW-1:0] ADDR_PORT = 3'd4;

    localparam logic [DW-1:0] KEY_SELECT = 32'h0000_0338;
    localparam logic [DW-1:0] KEY_RDARM  = 32'h0000_0538;
    localparam logic [DW-1:0] KEY_WRARM  = 32'h0000_0738;
    localparam logic [DW-1:0] WIN_BASE   = 32'h0000_1800;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_SEL  = 3'd1,
        SQ_WIN  = 3'd2,
        SQ_RARM = 3'd3,
        SQ_WARM = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic [PORT_AW-1:0] addr;
        logic [1:0]         size;
        logic [DW-1:0]      wdata;
    } port_req_t;

    function automatic logic [3:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            default: return 4'd4;
        endcase
    endfunction

    function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/unlock_seq.sv
module unlock_seq
    import ixwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  port_req_t        req,
    output seq_state_t       state,
    output logic [OFF_W-1:0] offset,
    output logic             cfg_we,
    output logic             cfg_rd_hit
);
    localparam logic [DW-1:0] LOW_MASK = DW'(CFG_DEPTH - 1);

    logic [DW-1:0]    wd;
    seq_state_t       nxt;
    logic [OFF_W-1:0] off_nxt;

    assign wd         = req.wdata & size_mask(req.size);
    assign cfg_we     = req.wr && !req.rd && state == SQ_WARM && req.addr == DATA_PORT;
    assign cfg_rd_hit = req.rd && state == SQ_RARM && req.addr == DATA_PORT;

    always_comb begin
        nxt     = state;
        off_nxt = offset;
        if (req.rd) begin
            nxt = SQ_IDLE;
        end else if (req.wr) begin
            case (state)
                SQ_IDLE: begin
                    if (req.addr == ADDR_PORT && wd == KEY_SELECT) nxt = SQ_SEL;
                end
                SQ_SEL: begin
                    nxt = SQ_IDLE;
                    if (req.addr == DATA_PORT && (wd & ~LOW_MASK) == WIN_BASE) begin
                        nxt     = SQ_WIN;
                        off_nxt = wd[OFF_W-1:0];
                    end
                end
                SQ_WIN: begin
                    nxt = SQ_IDLE;
                    if (req.addr == ADDR_PORT) begin
                        if (wd == KEY_RDARM)      nxt = SQ_RARM;
                        else if (wd == KEY_WRARM) nxt = SQ_WARM;
                    end
                end
                default: nxt = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            offset <= '0;
        end else begin
            state  <= nxt;
            offset <= off_nxt;
        end
    end
endmodule

// File: rtl/cfg_byte_ram.sv
module cfg_byte_ram
    import ixwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [7:0]       mem [CFG_DEPTH];
    logic [OFF_W-1:0] lane_idx [LANES];
    logic [3:0]       nb;

    assign nb = size_bytes(size);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign lane_idx[ln]     = off + OFF_W'(ln);
        assign rdata[8*ln +: 8] = (4'(ln) < nb) ? mem[lane_idx[ln]] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            for (int ln = 0; ln < LANES; ln++) begin
                if (4'(ln) < nb) mem[lane_idx[ln]] <= wdata[8*ln +: 8];
            end
        end
    end
endmodule

// File: rtl/port_cfg_backdoor.sv
module port_cfg_backdoor
    import ixwin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [PORT_AW-1:0] bus_addr,
    input  logic [1:0]         bus_size,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               bk_wr,
    output logic               bk_rd,
    output logic [PORT_AW-1:0] bk_addr,
    output logic [1:0]         bk_size,
    output logic [DW-1:0]      bk_wdata,
    input  logic [DW-1:0]      bk_rdata
);
    port_req_t        req;
    seq_state_t       state;
    logic [OFF_W-1:0] offset;
    logic             cfg_we;
    logic             cfg_rd_hit;
    logic [DW-1:0]    cfg_rdata;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, size: bus_size, wdata: bus_wdata};

    unlock_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .state      (state),
        .offset     (offset),
        .cfg_we     (cfg_we),
        .cfg_rd_hit (cfg_rd_hit)
    );

    cfg_byte_ram u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .off   (offset),
        .size  (bus_size),
        .wdata (bus_wdata),
        .rdata (cfg_rdata)
    );

    assign bk_wr     = bus_wr && !cfg_we;
    assign bk_rd     = bus_rd;
    assign bk_addr   = bus_addr;
    assign bk_size   = bus_size;
    assign bk_wdata  = bus_wdata;
    assign bus_rdata = cfg_rd_hit ? cfg_rdata : bk_rdata;
endmodule

// File: rtl/backdoor_chk.sv
module backdoor_chk
    import ixwin_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [PORT_AW-1:0] bus_addr,
    input logic [DW-1:0]      bus_wdata,
    input logic               bk_wr,
    input logic               bk_rd,
    input logic [DW-1:0]      bk_wdata,
    input seq_state_t         state,
    input logic               cfg_we
);
    // R6
    rd_forward_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> bk_rd);

    // R6
    rd_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> state == SQ_IDLE);

    // R5
    cfg_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> !bk_wr);

    // R5
    cfg_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> state == SQ_IDLE);

    // R7
    wr_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && !(state == SQ_WARM && bus_addr == DATA_PORT))
            |-> (bk_wr && bk_wdata == bus_wdata));

    // R4
    arm_origin_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == SQ_RARM || state == SQ_WARM) && !$stable(state))
            |-> $past(state) == SQ_WIN);

    // R2
    sel_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_SEL && !$stable(state))
            |-> ($past(state) == SQ_IDLE && $past(bus_addr) == ADDR_PORT));
endmodule

bind port_cfg_backdoor backdoor_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bk_wr     (bk_wr),
    .bk_rd     (bk_rd),
    .bk_wdata  (bk_wdata),
    .state     (state),
    .cfg_we    (cfg_we)
);

// File: tb/tb_port_cfg_backdoor.sv
module tb_port_cfg_backdoor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bk_wr, bk_rd;
    logic [2:0]  bk_addr;
    logic [1:0]  bk_size;
    logic [31:0] bk_wdata;
    logic [31:0] bk_rdata;

    int n_cmp = 0, n_bad = 0;
    int m_st  = 0;
    logic [7:0] m_off = 8'h00;
    logic [7:0] m_mem [256];
    bit   done = 1'b0;

    always #2 clk = ~clk;

    assign bk_rdata = 32'hC0DE_0000 | {29'd0, bk_addr};

    port_cfg_backdoor dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bk_wr(bk_wr), .bk_rd(bk_rd),
        .bk_addr(bk_addr), .bk_size(bk_size), .bk_wdata(bk_wdata),
        .bk_rdata(bk_rdata)
    );

    function automatic logic [31:0] msk(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int nby(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [1:0] sz, input string req);
        logic [31:0] md;
        bit consume;
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d; bus_size = sz;
        #1;
        md = d & msk(sz);
        consume = (m_st == 4 && a == 3'd0);
        check(bk_wr == !consume, req, {31'd0, bk_wr}, {31'd0, !consume});
        if (!consume)
            check(bk_addr == a && bk_wdata == d && bk_size == sz, "R7",
                  bk_wdata, d);
        @(posedge clk);
        case (m_st)
            0: if (a == 3'd4 && md == 32'h338) m_st = 1;
            1: begin
                m_st = 0;
                if (a == 3'd0 && (md & ~32'hFF) == 32'h1800) begin
                    m_st = 2; m_off = md[7:0];
                end
            end
            2: m_st = (a == 3'd4 && md == 32'h538) ? 3 :
                      (a == 3'd4 && md == 32'h738) ? 4 : 0;
            4: begin
                if (a == 3'd0)
                    for (int i = 0; i < nby(sz); i++) m_mem[8'(m_off + 8'(i))] = d[8*i +: 8];
                m_st = 0;
            end
            default: m_st = 0;
        endcase
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] sz, input string req);
        logic [31:0] exp;
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        if (m_st == 3 && a == 3'd0) begin
            exp = '0;
            for (int i = 0; i < nby(sz); i++) exp[8*i +: 8] = m_mem[8'(m_off + 8'(i))];
        end else begin
            exp = 32'hC0DE_0000 | {29'd0, a};
        end
        check(bus_rdata == exp, req, bus_rdata, exp);
        check(bk_rd == 1'b1, "R6", {31'd0, bk_rd}, 32'd1);
        @(posedge clk);
        m_st = 0;
        #1 bus_rd = 1'b0;
    endtask

    task automatic unlock(input logic [7:0] off, input bit is_wr, input string req);
        wr(3'd4, 32'h338, 2'd1, req);
        wr(3'd0, 32'h1800 | {24'd0, off}, 2'd2, req);
        wr(3'd4, is_wr ? 32'h738 : 32'h538, 2'd1, req);
    endtask

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: idle after reset, array zero
        rd(3'd0, 2'd2, "R1");
        unlock(8'h10, 1'b0, "R1");
        rd(3'd0, 2'd2, "R1");

        // R5/R6: write then read back
        unlock(8'h20, 1'b1, "R5");
        wr(3'd0, 32'h1122_3344, 2'd2, "R5");
        unlock(8'h20, 1'b0, "R6");
        rd(3'd0, 2'd2, "R6");
        unlock(8'h22, 1'b0, "R6");
        rd(3'd0, 2'd0, "R6");

        // R5: 2-byte write with junk above
        unlock(8'h40, 1'b1, "R5");
        wr(3'd0, 32'hAAAA_BEEF, 2'd1, "R5");
        unlock(8'h40, 1'b0, "R5");
        rd(3'd0, 2'd2, "R5");

        // R9: wrap past 255
        unlock(8'hFE, 1'b1, "R9");
        wr(3'd0, 32'hA1B2_C3D4, 2'd2, "R9");
        unlock(8'h00, 1'b0, "R9");
        rd(3'd0, 2'd0, "R9");

        // R2: stray writes in idle ignored
        wr(3'd0, 32'h338, 2'd1, "R2");
        wr(3'd4, 32'h339, 2'd1, "R2");
        unlock(8'h20, 1'b0, "R2");
        rd(3'd0, 2'd2, "R2");

        // R3: broken select step
        wr(3'd4, 32'h338, 2'd1, "R3");
        wr(3'd4, 32'h1820, 2'd2, "R3");
        wr(3'd4, 32'h538, 2'd1, "R3");
        rd(3'd0, 2'd2, "R3");
        wr(3'd4, 32'h338, 2'd1, "R3");
        wr(3'd0, 32'h1920, 2'd2, "R3");
        rd(3'd0, 2'd2, "R3");

        // R4: bad window key
        wr(3'd4, 32'h338, 2'd1, "R4");
        wr(3'd0, 32'h1820, 2'd2, "R4");
        wr(3'd4, 32'h638, 2'd1, "R4");
        rd(3'd0, 2'd2, "R4");

        // R6: read mid-chain drops to idle
        wr(3'd4, 32'h338, 2'd1, "R6");
        rd(3'd4, 2'd1, "R6");
        wr(3'd0, 32'h1820, 2'd2, "R6");
        wr(3'd4, 32'h538, 2'd1, "R6");
        rd(3'd0, 2'd2, "R6");

        // R8: write while read-armed
        unlock(8'h20, 1'b0, "R8");
        wr(3'd2, 32'h5555, 2'd1, "R8");
        rd(3'd0, 2'd2, "R8");

        // R5: write-armed, write to other offset forwarded
        unlock(8'h20, 1'b1, "R5");
        wr(3'd4, 32'h9999_9999, 2'd2, "R5");
        unlock(8'h20, 1'b0, "R5");
        rd(3'd0, 2'd2, "R5");

        // R10: size masking of magic values
        wr(3'd4, 32'h338, 2'd0, "R10");
        wr(3'd0, 32'h1820, 2'd2, "R10");
        wr(3'd4, 32'h538, 2'd1, "R10");
        rd(3'd0, 2'd2, "R10");
        wr(3'd4, 32'hFFFF_0338, 2'd1, "R10");
        wr(3'd0, 32'h1820, 2'd2, "R10");
        wr(3'd4, 32'h538, 2'd1, "R10");
        rd(3'd0, 2'd2, "R10");

        // R7: constrained random mix
        for (int k = 0; k < 600; k++) begin
            int kind;
            logic [1:0] sz;
            kind = int'($urandom_range(0, 6));
            sz   = 2'($urandom_range(0, 3));
            case (kind)
                0: wr(3'd4, 32'h338, 2'd1, "R7");
                1: wr(3'd0, 32'h1800 | 32'($urandom_range(0, 255)), 2'd2, "R7");
                2: wr(3'd4, ($urandom_range(0, 1) == 0) ? 32'h538 : 32'h738, 2'd1, "R7");
                3: wr(3'($urandom_range(0, 5)), $urandom(), sz, "R7");
                4: rd(3'($urandom_range(0, 5)), sz, "R7");
                5: wr(3'd0, $urandom(), sz, "R7");
                default: rd(3'd0, sz, "R7");
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule